// File: doc/BRIEF.md
# Hybrid Karatsuba GF(2^m) Multiplier

This block multiplies two elements of the binary field GF(2^M) in polynomial basis and returns their product reduced modulo a fixed irreducible polynomial. Bit i of an operand or result holds the coefficient of x^i. Addition of coefficients is XOR and multiplication of coefficients is AND, so no carry chain appears anywhere in the datapath.

The carry-less product is built by a recursive Karatsuba split. An operand of N bits, with N at or above a split threshold (29 by default), is cut at L = ceil(N/2) into a low half (bits L-1..0) and a high half (bits N-1..L). Three sub-products are formed: low by low, high by high (N-L bits wide), and the XOR of the halves of A by the XOR of the halves of B (the high half zero-extended to L bits). They are recombined by shifts and XOR into the 2N-1 bit product. Below the threshold a flat leaf multiplier takes over; a parameter selects either a general Karatsuba leaf or a schoolbook leaf. The 2M-1 bit product is then folded from its top bit down by the reduction polynomial.

The operands enter through a valid/ready stream and the result leaves through another. With the output register on, a beat is accepted whenever the output slot is empty or is being emptied in the same cycle, and the result appears one cycle later and is held while the consumer stalls. With the register off, the block is purely combinational and ready and valid pass straight through.

Top module: `gf2_kara_mul`

## Requirements
- R1: out_data equals in_a times in_b in GF(2^M) modulo POLY; with default parameters M = 233 and POLY = x^233 + x^74 + 1 (bits 233, 74 and 0 set).
- R2: When either operand is zero, the result is zero.
- R3: When in_b holds the field element one (only bit 0 set), the result equals in_a.
- R4: Swapping in_a and in_b gives the same result.
- R5: Operands with all M bits set, whose unreduced product reaches degree 2M-2, give the correct fully reduced result.
- R6: While rst_n is low and in the first cycle after it, with OUT_REG = 1, out_valid is 0 and in_ready is 1.
- R7: With OUT_REG = 1, a beat accepted on a clock edge (in_valid and in_ready both 1) yields out_valid = 1 and its result on out_data after that edge.
- R8: With OUT_REG = 1, while out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid and out_data keep their values on the next edge.
- R9: With OUT_REG = 0, out_valid follows in_valid, in_ready follows out_ready, and out_data carries the result of the present operands in the same cycle.
- R10: For odd M with a small threshold that forces several split levels with unequal halves, and with the schoolbook leaf, results still meet R1.
- R11: With OUT_REG = 1, when out_valid and out_ready are 1 and no new beat is accepted, out_valid is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| in_a | input | M | First field element |
| in_b | input | M | Second field element |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | M | Reduced field product |

## Verification
The bench builds two copies: the default M = 233 instance with the trinomial, threshold 29, general Karatsuba leaves and the output register, which reaches four split levels with both even and odd halves; and an M = 13 instance with x^13 + x^4 + x^3 + x + 1, threshold 4, schoolbook leaves and no register, which reaches splits down to 2-bit and 3-bit leaves and the pass-through handshake. Results are compared against a bit-serial shift-and-add reference computed in the bench, over random operands, zero, one and all-ones, and the stream handshake is exercised with stalls and back-to-back beats.

// File: rtl/gf2_kara_pkg.sv
package gf2_kara_pkg;
  // Leaf variant used below the split threshold.
  typedef enum logic [0:0] {
    LEAF_SCHOOL = 1'b0,
    LEAF_GKA    = 1'b1
  } leaf_kind_e;

  localparam int DEFAULT_SPLIT_MIN = 29;
endpackage

// File: rtl/gf2_kara_leaf.sv
module gf2_kara_leaf #(
  parameter int N = 8,
  parameter gf2_kara_pkg::leaf_kind_e KIND = gf2_kara_pkg::LEAF_GKA
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-2:0] p
);
  localparam int W = 2 * N - 1;

  generate
    if (KIND == gf2_kara_pkg::LEAF_GKA) begin : g_gka
      // Flat Karatsuba: pair terms (a_s^a_t)(b_s^b_t) plus single terms a_i*b_i
      // spread over every output degree the index i can pair into.
      always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int s = 0; s < N; s++) begin
          for (int t = s + 1; t < N; t++) begin
            acc[s+t] = acc[s+t] ^ ((a[s] ^ a[t]) & (b[s] ^ b[t]));
          end
        end
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N; j++) begin
            acc[i+j] = acc[i+j] ^ (a[i] & b[i]);
          end
        end
        p = acc;
      end
    end else begin : g_school
      always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N; j++) begin
            acc[i+j] = acc[i+j] ^ (a[i] & b[j]);
          end
        end
        p = acc;
      end
    end
  endgenerate
endmodule

// File: rtl/gf2_kara_node.sv
module gf2_kara_node #(
  parameter int N = 233,
  parameter int SPLIT_MIN = gf2_kara_pkg::DEFAULT_SPLIT_MIN,
  parameter gf2_kara_pkg::leaf_kind_e KIND = gf2_kara_pkg::LEAF_GKA
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-2:0] p
);
  localparam int W = 2 * N - 1;

  generate
    if (N < SPLIT_MIN || N < 2) begin : g_leaf
      gf2_kara_leaf #(.N(N), .KIND(KIND)) u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int L  = (N + 1) / 2;
      localparam int H  = N - L;
      localparam int WL = 2 * L - 1;
      localparam int WH = 2 * H - 1;

      logic [L-1:0]  a_lo, b_lo, a_x, b_x;
      logic [H-1:0]  a_hi, b_hi;
      logic [WL-1:0] p_lo, p_x, mid;
      logic [WH-1:0] p_hi;

      assign a_lo = a[L-1:0];
      assign b_lo = b[L-1:0];
      assign a_hi = a[N-1:L];
      assign b_hi = b[N-1:L];
      // High half is zero-extended to the low width before mixing.
      assign a_x  = a_lo ^ L'(a_hi);
      assign b_x  = b_lo ^ L'(b_hi);

      gf2_kara_node #(.N(L), .SPLIT_MIN(SPLIT_MIN), .KIND(KIND))
        u_lo (.a(a_lo), .b(b_lo), .p(p_lo));
      gf2_kara_node #(.N(L), .SPLIT_MIN(SPLIT_MIN), .KIND(KIND))
        u_x  (.a(a_x),  .b(b_x),  .p(p_x));
      gf2_kara_node #(.N(H), .SPLIT_MIN(SPLIT_MIN), .KIND(KIND))
        u_hi (.a(a_hi), .b(b_hi), .p(p_hi));

      assign mid = p_lo ^ p_x ^ WL'(p_hi);
      assign p   = (W'(p_hi) << (2 * L)) ^ (W'(mid) << L) ^ W'(p_lo);
    end
  endgenerate
endmodule

// File: rtl/gf2_reduce.sv
module gf2_reduce #(
  parameter int M = 233,
  parameter logic [M:0] POLY = (M+1)'(1) << M
) (
  input  logic [2*M-2:0] full,
  output logic [M-1:0]   res
);
  // Fold from the top degree down; each step clears bit i using POLY << (i-M).
  always_comb begin
    logic [2*M-2:0] r;
    r = full;
    for (int i = 2 * M - 2; i >= M; i--) begin
      if (r[i]) r[i -: M+1] = r[i -: M+1] ^ POLY;
    end
    res = r[M-1:0];
  end
endmodule

// File: rtl/gf2_kara_mul.sv
module gf2_kara_mul #(
  parameter int M = 233,
  parameter logic [M:0] POLY = ((M+1)'(1) << 233) | ((M+1)'(1) << 74) | (M+1)'(1),
  parameter int SPLIT_MIN = gf2_kara_pkg::DEFAULT_SPLIT_MIN,
  parameter gf2_kara_pkg::leaf_kind_e LEAF = gf2_kara_pkg::LEAF_GKA,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_data
);
  localparam logic [M-1:0] ONE = M'(1);

  logic [2*M-2:0] prod_full;
  logic [M-1:0]   prod;

  gf2_kara_node #(.N(M), .SPLIT_MIN(SPLIT_MIN), .KIND(LEAF))
    u_core (.a(in_a), .b(in_b), .p(prod_full));

  gf2_reduce #(.M(M), .POLY(POLY)) u_red (.full(prod_full), .res(prod));

  generate
    if (OUT_REG) begin : g_reg
      logic         vld_q;
      logic [M-1:0] dat_q;
      logic         take;

      assign in_ready  = !vld_q || out_ready;
      assign take      = in_valid && in_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          if (take) begin
            vld_q <= 1'b1;
            dat_q <= prod;
          end else if (out_ready) begin
            vld_q <= 1'b0;
          end
        end
      end

      assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
      assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
      assert_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);
      assert_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_b == ONE) |=> out_data == $past(in_a));
      assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_a == '0) |=> out_data == '0);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = prod;

      assert_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_b == ONE) |-> out_data == in_a);
      assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_b == '0) |-> out_data == '0);
    end
  endgenerate
endmodule

// File: tb/tb_gf2_kara_mul.sv
module tb_gf2_kara_mul;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 233;
  localparam logic [MB:0] PB = ((MB+1)'(1) << 233) | ((MB+1)'(1) << 74) | (MB+1)'(1);
  localparam int MS = 13;
  localparam logic [MS:0] PS = 14'h201B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic          in_ready, out_valid;
  logic [MB-1:0] in_a = '0, in_b = '0, out_data;

  logic          s_in_valid = 1'b0, s_out_ready = 1'b0;
  logic          s_in_ready, s_out_valid;
  logic [MS-1:0] s_a = '0, s_b = '0, s_out;

  gf2_kara_mul #(.M(MB), .POLY(PB), .SPLIT_MIN(29),
                 .LEAF(gf2_kara_pkg::LEAF_GKA), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  gf2_kara_mul #(.M(MS), .POLY(PS), .SPLIT_MIN(4),
                 .LEAF(gf2_kara_pkg::LEAF_SCHOOL), .OUT_REG(1'b0)) dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_a(s_a), .in_b(s_b), .out_valid(s_out_valid), .out_ready(s_out_ready),
    .out_data(s_out));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  function automatic logic [255:0] ref_mul(input logic [255:0] a, input logic [255:0] b,
                                           input int m, input logic [255:0] poly);
    logic [255:0] r;
    r = '0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[m]) r = r ^ poly;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [MB-1:0] rnd_big();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v[MB-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One beat through the registered instance; result sampled at the next falling edge.
  task automatic big_beat(input logic [MB-1:0] a, input logic [MB-1:0] b,
                          input string req, output logic [MB-1:0] got);
    logic [255:0] exp;
    exp = ref_mul(256'(a), 256'(b), MB, 256'(PB));
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid(R7)"}, 256'(out_valid), 256'd1);
    check(out_data == exp[MB-1:0], req, 256'(out_data), exp);
    got = out_data;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R6 out_valid in reset", 256'(out_valid), 256'd0);
    check(in_ready == 1'b1, "R6 in_ready in reset", 256'(in_ready), 256'd1);
    @(negedge clk); rst_n = 1'b1;
    check(out_valid == 1'b0, "R6 out_valid after reset", 256'(out_valid), 256'd0);
  endtask

  task automatic t_zero_one();
    logic [MB-1:0] g, x;
    x = rnd_big();
    big_beat('0, x, "R2 zero*x", g);
    big_beat(x, '0, "R2 x*zero", g);
    big_beat(x, MB'(1), "R3 x*one", g);
    check(g == x, "R3 x*one==x", 256'(g), 256'(x));
  endtask

  task automatic t_random();
    logic [MB-1:0] a, b, g1, g2;
    for (int k = 0; k < 40; k++) begin
      a = rnd_big(); b = rnd_big();
      big_beat(a, b, "R1 random", g1);
      big_beat(b, a, "R1 random swapped", g2);
      check(g1 == g2, "R4 commutative", 256'(g2), 256'(g1));
    end
  endtask

  task automatic t_allones();
    logic [MB-1:0] g;
    big_beat('1, '1, "R5 ones*ones", g);
    big_beat('1, MB'(1) << (MB-1), "R5 ones*top", g);
  endtask

  task automatic t_stall();
    logic [MB-1:0] a1, b1, a2, b2, held;
    logic [255:0] e1, e2;
    a1 = rnd_big(); b1 = rnd_big(); a2 = rnd_big(); b2 = rnd_big();
    e1 = ref_mul(256'(a1), 256'(b1), MB, 256'(PB));
    e2 = ref_mul(256'(a2), 256'(b2), MB, 256'(PB));
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_a = a1; in_b = b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R7 stalled beat valid", 256'(out_valid), 256'd1);
    check(out_data == e1[MB-1:0], "R7 stalled beat data", 256'(out_data), e1);
    check(in_ready == 1'b0, "R8 in_ready low on stall", 256'(in_ready), 256'd0);
    held = out_data;
    in_a = a2; in_b = b2;
    @(negedge clk);
    check(out_valid == 1'b1 && out_data == held, "R8 held under stall",
          256'(out_data), 256'(held));
    out_ready = 1'b1;
    @(negedge clk);
    check(out_data == e2[MB-1:0], "R7 back-to-back beat", 256'(out_data), e2);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 retire without new beat", 256'(out_valid), 256'd0);
  endtask

  task automatic t_small();
    logic [255:0] e, e_sw;
    logic [MS-1:0] a, b, g;
    @(negedge clk);
    s_in_valid = 1'b1; s_out_ready = 1'b0; #1;
    check(s_out_valid == 1'b1 && s_in_ready == 1'b0, "R9 handshake pass 1",
          256'({s_out_valid, s_in_ready}), 256'(2'b10));
    s_in_valid = 1'b0; s_out_ready = 1'b1; #1;
    check(s_out_valid == 1'b0 && s_in_ready == 1'b1, "R9 handshake pass 2",
          256'({s_out_valid, s_in_ready}), 256'(2'b01));
    s_in_valid = 1'b1;
    for (int k = 0; k < 300; k++) begin
      a = MS'($urandom); b = MS'($urandom);
      if (k == 0) begin a = '1; b = '1; end
      s_a = a; s_b = b; #1;
      e = ref_mul(256'(a), 256'(b), MS, 256'(PS));
      check(s_out == e[MS-1:0], "R10 small odd M deep split", 256'(s_out), e);
      g = s_out;
      s_a = b; s_b = a; #1;
      e_sw = 256'(g);
      check(s_out == g, "R4 small commutative", 256'(s_out), e_sw);
    end
    s_in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_zero_one();
    t_random();
    t_allones();
    t_stall();
    t_small();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule